// File: doc/BRIEF.md
# Correctable Error Injection Register Bank

This block gives software one control register and one status register for each of several ports. A port's control register can raise one artificial correctable receiver error. The block merges that injected event with the real receiver-error input of the same port, so logic further on sees the two as the same kind of error.

The merged error sets a sticky status bit, and software clears that bit by writing 1 to it. A mask bit beside the status bit decides whether a recorded error is passed on. Errors on this path are reported only through the internal error structure and never start a message-signalled interrupt. The block has no interrupt output.

The address is `{port index, register select}`. A register select of 0 picks the control register, with the disable flag in bit 0 and the inject flag in bit 1. A register select of 1 picks the status register, with the status flag in bit 0 and the mask flag in bit 1. Reads are combinational from the current register state.

Top module: `err_inject_ctrl`

## Requirements
- R1: After reset, every control and status register reads 0, and `err_o` and `cor_err_o` are 0.
- R2: If a control write takes bit 1 from 0 to 1 while the disable flag is 0, `err_o` for that port is 1 for exactly the one cycle that follows the write edge.
- R3: A control write that keeps bit 1 at 1 produces no pulse. Another pulse needs a write of 0 to bit 1 first.
- R4: `err_o[p]` is the OR of the injected pulse and `rx_err_i[p]`, and it reacts to `rx_err_i` in the same cycle.
- R5: While the disable flag (control bit 0) is 1, writes to bit 1 produce no pulse. A write that sets both bits at once produces no pulse.
- R6: The first control write to a port after reset loads the disable flag. Later writes leave it unchanged until the next reset.
- R7: The status flag (status bit 0) is set at the clock edge that ends a cycle with `err_o[p]` high. It stays set until software writes 1 to status bit 0. A set caused by an error in the same cycle as the clear takes priority.
- R8: The mask flag (status bit 1) is read/write and resets to 0. `cor_err_o[p]` is the status flag ANDed with the inverted mask flag. Masking does not stop the status flag from being recorded.
- R9: Bits above bit 1 of every register read 0, and writing them has no effect.
- R10: If a real error and an injected pulse occur in the same cycle, `err_o[p]` is high for that one cycle only, and the status flag is set once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Port index in the upper bits, register select in bit 0 |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the addressed register |
| rx_err_i | input | NUM_PORTS | Real receiver-error event, one per port |
| err_o | output | NUM_PORTS | Merged error, injected pulse OR real error |
| cor_err_o | output | NUM_PORTS | Status flag that the mask lets through |

## Verification
The write-once lock is the hardest case to reach. Whichever control write comes first after reset fixes the disable flag for the rest of the run. For that reason the bench gives each port its own role: one port is locked enabled by its first write, and another is locked disabled, also by its first write. Later writes to each then test that the flag does not move. The coincident case is forced by timing a real error on the same port for the cycle right after an injecting write, which is the cycle the pulse appears. A scoreboard then checks that `err_o` stays high for one cycle only.

// File: rtl/err_inject_pkg.sv
package err_inject_pkg;
  localparam int unsigned CTRL_DIS_BIT  = 0;
  localparam int unsigned CTRL_INJ_BIT  = 1;
  localparam int unsigned STAT_FLAG_BIT = 0;
  localparam int unsigned STAT_MASK_BIT = 1;

  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/err_inj_port.sv
module err_inj_port
  import err_inject_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic       dis_o,
  output logic       inj_o,
  output logic       pulse_o
);
  logic dis_q, inj_q, locked_q, pulse_q;
  logic dis_new;

  // disable flag takes the written value only on the first write after reset
  assign dis_new = locked_q ? dis_q : wdata_i[CTRL_DIS_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q    <= 1'b0;
      inj_q    <= 1'b0;
      locked_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (wr_i) begin
        dis_q    <= dis_new;
        inj_q    <= wdata_i[CTRL_INJ_BIT];
        locked_q <= 1'b1;
        pulse_q  <= wdata_i[CTRL_INJ_BIT] & ~inj_q & ~dis_new;
      end
    end
  end

  assign dis_o   = dis_q;
  assign inj_o   = inj_q;
  assign pulse_o = pulse_q;

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  p_no_pulse_dis_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> !dis_q);
  p_dis_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(dis_q));
endmodule

// File: rtl/err_stat_bit.sv
module err_stat_bit
  import err_inject_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       err_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output logic       stat_o,
  output logic       mask_o,
  output logic       report_o
);
  logic stat_q, mask_q, clr;

  assign clr = wr_i & wdata_i[STAT_FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | err_i;  // a new error beats the clear
      if (wr_i) mask_q <= wdata_i[STAT_MASK_BIT];
    end
  end

  assign stat_o   = stat_q;
  assign mask_o   = mask_q;
  assign report_o = stat_q & ~mask_q;

  p_err_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> stat_q);
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr) |=> stat_q);
  p_mask_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/err_inject_ctrl.sv
module err_inject_ctrl
  import err_inject_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_PORTS-1:0] rx_err_i,
  output logic [NUM_PORTS-1:0] err_o,
  output logic [NUM_PORTS-1:0] cor_err_o
);
  localparam int unsigned PORT_W = ADDR_W - 1;

  logic [PORT_W-1:0]    port_sel;
  reg_sel_e             reg_sel;
  logic [NUM_PORTS-1:0] hit, pulse, dis, inj, stat, mask;

  assign port_sel = addr_i[ADDR_W-1:1];
  assign reg_sel  = reg_sel_e'(addr_i[0]);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign hit[i] = (port_sel == PORT_W'(i));

    err_inj_port u_inj (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i & hit[i] & (reg_sel == REG_CTRL)),
      .wdata_i (wdata_i[1:0]),
      .dis_o   (dis[i]),
      .inj_o   (inj[i]),
      .pulse_o (pulse[i])
    );

    assign err_o[i] = pulse[i] | rx_err_i[i];

    err_stat_bit u_stat (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .err_i    (err_o[i]),
      .wr_i     (we_i & hit[i] & (reg_sel == REG_STAT)),
      .wdata_i  (wdata_i[1:0]),
      .stat_o   (stat[i]),
      .mask_o   (mask[i]),
      .report_o (cor_err_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (hit[i]) begin
        if (reg_sel == REG_CTRL) begin
          rdata_o[CTRL_DIS_BIT] = dis[i];
          rdata_o[CTRL_INJ_BIT] = inj[i];
        end else begin
          rdata_o[STAT_FLAG_BIT] = stat[i];
          rdata_o[STAT_MASK_BIT] = mask[i];
        end
      end
    end
  end

  p_rdata_rsvd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:2] == '0);
endmodule

// File: tb/test_err_inject_ctrl.sv
`timescale 1ns/1ps
module test_err_inject_ctrl;
  localparam int N  = 4;
  localparam int AW = 3;
  localparam int DW = 32;

  typedef struct {
    logic [N-1:0] err;
    logic [N-1:0] rep;
    string        tag;
  } item_t;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic          we = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  rx = '0;
  logic [N-1:0]  err, cor;

  int n_tests = 0, n_fail = 0;
  item_t q[$];
  bit done = 0;

  logic [N-1:0] m_dis = '0, m_lock = '0, m_inj = '0, m_stat = '0, m_mask = '0, pend = '0;

  always #5 clk = ~clk;

  err_inject_ctrl #(.NUM_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) i_err_inject_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .rx_err_i(rx), .err_o(err), .cor_err_o(cor)
  );

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_tests++;
      if (err !== it.err || cor !== it.rep) begin
        n_fail++;
        $display("FAIL %s: err=%b cor=%b expected err=%b cor=%b", it.tag, err, cor, it.err, it.rep);
      end
    end
  end

  // driver: one cycle of stimulus, model updates for the closing edge
  task automatic step(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                      input logic [N-1:0] r, input string tag);
    item_t it;
    logic [N-1:0] e, np, clr;
    int p;
    @(posedge clk); #1;
    addr = a; we = w; wdata = d; rx = r;
    e = pend | r;
    it.err = e; it.rep = m_stat & ~m_mask; it.tag = tag;
    q.push_back(it);
    np = '0; clr = '0;
    p = int'(a[AW-1:1]);
    if (w) begin
      if (a[0] == 1'b0) begin
        logic nd;
        nd = m_lock[p] ? m_dis[p] : d[0];
        if (d[1] && !m_inj[p] && !nd) np[p] = 1'b1;
        m_dis[p] = nd; m_inj[p] = d[1]; m_lock[p] = 1'b1;
      end else begin
        clr[p] = d[0]; m_mask[p] = d[1];
      end
    end
    m_stat = (m_stat & ~clr) | e;
    pend = np;
  endtask

  task automatic wr(input int p, input logic sel, input logic [DW-1:0] d, input string tag);
    step({p[AW-2:0], sel}, 1'b1, d, '0, tag);
  endtask

  task automatic idle(input logic [N-1:0] r, input string tag);
    step('0, 1'b0, '0, r, tag);
  endtask

  task automatic rd(input int p, input logic sel, input string tag);
    logic [DW-1:0] exp;
    exp = '0;
    if (sel == 1'b0) exp[1:0] = {m_inj[p], m_dis[p]};
    else             exp[1:0] = {m_mask[p], m_stat[p]};
    step({p[AW-2:0], sel}, 1'b0, '0, '0, tag);
    @(negedge clk); #1;
    n_tests++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected %h", tag, rdata, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int p = 0; p < N; p++) begin
      rd(p, 1'b0, "R1 ctrl reset");
      rd(p, 1'b1, "R1 stat reset");
    end
    // R2 rising inject on port 0 (also locks enabled, R6)
    wr(0, 1'b0, 32'h2, "R2 inject write");
    idle('0, "R2 pulse cycle");
    idle('0, "R2 pulse ended");
    // R3 write 1 while already 1
    wr(0, 1'b0, 32'h2, "R3 hold write");
    idle('0, "R3 no pulse");
    wr(0, 1'b0, 32'h0, "R3 clear inject");
    wr(0, 1'b0, 32'h2, "R3 re-arm");
    idle('0, "R3 second pulse");
    rd(0, 1'b1, "R7 status after inject");
    wr(0, 1'b1, 32'h1, "R7 clear status");
    rd(0, 1'b1, "R7 status cleared");
    // R6 port 0 locked enabled: try setting disable
    wr(0, 1'b0, 32'h1, "R6 disable ignored");
    rd(0, 1'b0, "R6 ctrl readback");
    wr(0, 1'b0, 32'h2, "R6 inject still works");
    idle('0, "R6 pulse");
    // R4 real error on port 1
    idle(4'b0010, "R4 real error");
    idle('0, "R4 real error gone");
    rd(1, 1'b1, "R7 sticky status p1");
    idle('0, "R7 still set");
    // R7 clear coincident with new error: set wins
    step({2'd1, 1'b1}, 1'b1, 32'h1, 4'b0010, "R7 clear vs error");
    rd(1, 1'b1, "R7 set wins");
    wr(1, 1'b1, 32'h1, "R7 clear p1");
    rd(1, 1'b1, "R7 cleared p1");
    // R8 mask on port 2
    wr(2, 1'b1, 32'h2, "R8 set mask");
    idle(4'b0100, "R8 error masked");
    idle('0, "R8 report blocked");
    rd(2, 1'b1, "R8 status recorded");
    wr(2, 1'b1, 32'h0, "R8 unmask");
    idle('0, "R8 report passes");
    // R5 / R6 port 3 locked disabled
    wr(3, 1'b0, 32'h3, "R5 set both");
    idle('0, "R5 no pulse set both");
    wr(3, 1'b0, 32'h0, "R6 try clear disable");
    rd(3, 1'b0, "R6 disable locked");
    wr(3, 1'b0, 32'h2, "R5 inject blocked");
    idle('0, "R5 no pulse");
    rd(3, 1'b1, "R5 status untouched");
    // R9 reserved bits
    wr(1, 1'b0, 32'hFFFF_FFFC, "R9 reserved ctrl write");
    rd(1, 1'b0, "R9 ctrl reads zero");
    wr(1, 1'b1, 32'hFFFF_FFFC, "R9 reserved stat write");
    rd(1, 1'b1, "R9 stat reads zero");
    // R10 coincident real and injected on port 0
    wr(0, 1'b1, 32'h1, "R10 clear status");
    wr(0, 1'b0, 32'h0, "R10 clear inject");
    wr(0, 1'b0, 32'h2, "R10 inject");
    idle(4'b0001, "R10 coincident");
    idle('0, "R10 single cycle");
    rd(0, 1'b1, "R10 status once");
    wr(0, 1'b1, 32'h1, "R10 single clear");
    rd(0, 1'b1, "R10 cleared by one write");
    idle('0, "idle");
    @(negedge clk); #2;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule